// File: doc/BRIEF.md
# Code Segment Mode and Size Decoder

This block turns the code-segment attribute bits held by an instruction front end into the execution mode and the effective operand and address widths for the instruction being issued. It takes the long-mode-active flag, the protection-enable flag, the segment's long bit and default-size bit, and three prefix indications for the current instruction: an operand-size prefix, an address-size prefix and a 64-bit operand request. Descriptor fetch and prefix parsing happen upstream. The block only receives bits that have already been extracted.

Decoding is combinational. A single register stage holds the result. A new result appears at the outputs one clock after the cycle in which `in_valid` is high, and the outputs hold their values while `in_valid` stays low. The pair long bit = 1, default bit = 1 has no meaning under long mode. For that pair the block reports a reserved mode and raises a one-cycle fault strobe, and the size outputs keep their previous values.

Top module: `csm_decoder`

## Requirements
- R1: While `rst_n` is low, the outputs are forced to mode 2'b00 (legacy), operand size 2'b01 and address size 2'b01 (32-bit), with `fault_o` low.
- R2: The outputs change only at the clock edge where `in_valid` is high, and the new value is visible one cycle after the strobe. While `in_valid` is low, `mode_o`, `op_size_o` and `ad_size_o` hold their values.
- R3: With `lma_active`=1, `prot_en`=1, `cs_l`=1 and `cs_d`=0, and no prefixes, the result is mode 2'b10 (64-bit), operand size 2'b01 (32) and address size 2'b10 (64).
- R4: In 64-bit mode, `req_w64` gives operand size 2'b10 (64). Otherwise `pfx_opsize` gives 2'b00 (16). `req_w64` wins when both are set. `pfx_adsize` gives address size 2'b01 (32).
- R5: With `lma_active`=1, `prot_en`=1 and `cs_l`=0, the mode is 2'b01 (compatibility). `cs_d`=1 gives 32-bit default sizes (2'b01) and `cs_d`=0 gives 16-bit default sizes (2'b00).
- R6: With `lma_active`=1, `prot_en`=1, `cs_l`=1 and `cs_d`=1, the mode becomes 2'b11 (reserved) and `fault_o` is high for exactly the one cycle after the strobe. Both size outputs keep their previous values.
- R7: With `lma_active`=0 and `prot_en`=1, the mode is 2'b00 (legacy) whatever the value of `cs_l`. `cs_d` selects 32-bit (2'b01) or 16-bit (2'b00) defaults.
- R8: In legacy and compatibility modes, `pfx_opsize` flips the operand size between 16 and 32, and `pfx_adsize` flips the address size the same way. `req_w64` has no effect in these modes, and no size output ever shows 2'b10 in them.
- R9: With `prot_en`=0, long mode is treated as inactive. The result is legacy decoding as in R7, and `fault_o` is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Strobe that loads a new decode |
| lma_active | input | 1 | Long mode active flag |
| prot_en | input | 1 | Protection enable flag |
| cs_l | input | 1 | Code segment long bit |
| cs_d | input | 1 | Code segment default-size bit |
| pfx_opsize | input | 1 | Operand-size prefix present |
| pfx_adsize | input | 1 | Address-size prefix present |
| req_w64 | input | 1 | 64-bit operand request present |
| mode_o | output | 2 | 00 legacy, 01 compatibility, 10 64-bit, 11 reserved |
| op_size_o | output | 2 | Effective operand size: 00 16, 01 32, 10 64 |
| ad_size_o | output | 2 | Effective address size: 00 16, 01 32, 10 64 |
| fault_o | output | 1 | One-cycle strobe for a reserved encoding |

## Verification
The only internal state is the output register, so a wrong internal state shows up at the ports in the cycle after the strobe that loaded it. A bad mode gate shows as a legacy or compatibility mode with a 64-bit size, or as a 64-bit mode with a 16-bit address. A fault strobe that sticks, or sizes that move on a reserved decode, show up one cycle after the reserved input. A missing hold shows as outputs that drift while the strobe is low. The vector sequence is ordered so that each reserved decode follows a known size state, which lets any change to the held sizes be seen directly.

// File: rtl/csm_pkg.sv
package csm_pkg;

  localparam int unsigned CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    MODE_LEGACY = 2'b00,
    MODE_COMPAT = 2'b01,
    MODE_LONG64 = 2'b10,
    MODE_RSVD   = 2'b11
  } mode_e;

  typedef enum logic [CODE_W-1:0] {
    SZ16 = 2'b00,
    SZ32 = 2'b01,
    SZ64 = 2'b10
  } size_e;

  // Flip between the two legacy widths.
  function automatic size_e flip_legacy(input size_e s);
    return (s == SZ16) ? SZ32 : SZ16;
  endfunction

endpackage

// File: rtl/csm_mode_classify.sv
module csm_mode_classify
  import csm_pkg::*;
(
  input  logic  lma_active,
  input  logic  prot_en,
  input  logic  cs_l,
  input  logic  cs_d,
  output mode_e mode,
  output logic  rsvd
);

  logic long_on;

  always_comb begin
    long_on = lma_active & prot_en;
    if (!long_on) begin
      mode = MODE_LEGACY;
    end else begin
      unique case ({cs_l, cs_d})
        2'b10:   mode = MODE_LONG64;
        2'b11:   mode = MODE_RSVD;
        default: mode = MODE_COMPAT;
      endcase
    end
    rsvd = (mode == MODE_RSVD);
  end

endmodule

// File: rtl/csm_size_resolve.sv
module csm_size_resolve
  import csm_pkg::*;
(
  input  mode_e mode,
  input  logic  cs_d,
  input  logic  pfx_opsize,
  input  logic  pfx_adsize,
  input  logic  req_w64,
  output size_e op_size,
  output size_e ad_size
);

  size_e dflt;

  always_comb begin
    dflt = cs_d ? SZ32 : SZ16;
    unique case (mode)
      MODE_LONG64: begin
        if (req_w64)         op_size = SZ64;
        else if (pfx_opsize) op_size = SZ16;
        else                 op_size = SZ32;
        ad_size = pfx_adsize ? SZ32 : SZ64;
      end
      MODE_RSVD: begin
        op_size = SZ32;
        ad_size = SZ32;
      end
      default: begin
        op_size = pfx_opsize ? flip_legacy(dflt) : dflt;
        ad_size = pfx_adsize ? flip_legacy(dflt) : dflt;
      end
    endcase
  end

endmodule

// File: rtl/csm_out_reg.sv
module csm_out_reg
  import csm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  mode_e mode_n,
  input  logic  rsvd_n,
  input  size_e op_n,
  input  size_e ad_n,
  output mode_e mode_q,
  output size_e op_q,
  output size_e ad_q,
  output logic  fault_q
);

  mode_e mode_d;
  size_e op_d, ad_d;
  logic  fault_d;

  always_comb begin
    mode_d  = mode_q;
    op_d    = op_q;
    ad_d    = ad_q;
    fault_d = 1'b0;
    if (en) begin
      mode_d  = mode_n;
      fault_d = rsvd_n;
      if (!rsvd_n) begin
        op_d = op_n;
        ad_d = ad_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_LEGACY;
      op_q    <= SZ32;
      ad_q    <= SZ32;
      fault_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      op_q    <= op_d;
      ad_q    <= ad_d;
      fault_q <= fault_d;
    end
  end

  p_fault_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> mode_q == MODE_RSVD);
  p_fault_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !fault_q);
  p_rsvd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en && rsvd_n |=> $stable(op_q) && $stable(ad_q));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(mode_q) && $stable(op_q) && $stable(ad_q));

endmodule

// File: rtl/csm_decoder.sv
module csm_decoder
  import csm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       lma_active,
  input  logic       prot_en,
  input  logic       cs_l,
  input  logic       cs_d,
  input  logic       pfx_opsize,
  input  logic       pfx_adsize,
  input  logic       req_w64,
  output logic [1:0] mode_o,
  output logic [1:0] op_size_o,
  output logic [1:0] ad_size_o,
  output logic       fault_o
);

  mode_e mode_c, mode_q;
  logic  rsvd_c;
  size_e op_c, ad_c, op_q, ad_q;

  csm_mode_classify u_cls (
    .lma_active (lma_active),
    .prot_en    (prot_en),
    .cs_l       (cs_l),
    .cs_d       (cs_d),
    .mode       (mode_c),
    .rsvd       (rsvd_c)
  );

  csm_size_resolve u_sz (
    .mode       (mode_c),
    .cs_d       (cs_d),
    .pfx_opsize (pfx_opsize),
    .pfx_adsize (pfx_adsize),
    .req_w64    (req_w64),
    .op_size    (op_c),
    .ad_size    (ad_c)
  );

  csm_out_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (in_valid),
    .mode_n  (mode_c),
    .rsvd_n  (rsvd_c),
    .op_n    (op_c),
    .ad_n    (ad_c),
    .mode_q  (mode_q),
    .op_q    (op_q),
    .ad_q    (ad_q),
    .fault_q (fault_o)
  );

  assign mode_o    = mode_q;
  assign op_size_o = op_q;
  assign ad_size_o = ad_q;

  p_no_wide_legacy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00 || mode_o == 2'b01) |-> op_size_o != 2'b10 && ad_size_o != 2'b10);
  p_long_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 2'b10 |-> ad_size_o != 2'b00);
  p_w64_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && lma_active && prot_en && cs_l && !cs_d && req_w64 |=> op_size_o == 2'b10);
  p_lma_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !lma_active |=> mode_o == 2'b00);
  p_prot_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !prot_en |=> mode_o == 2'b00 && !fault_o);

endmodule

// File: tb/csm_decoder_test.sv
module csm_decoder_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, lma_active = 1'b0, prot_en = 1'b0, cs_l = 1'b0, cs_d = 1'b0;
  logic pfx_opsize = 1'b0, pfx_adsize = 1'b0, req_w64 = 1'b0;
  logic [1:0] mode_o, op_size_o, ad_size_o;
  logic fault_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  csm_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lma_active(lma_active),
    .prot_en(prot_en), .cs_l(cs_l), .cs_d(cs_d), .pfx_opsize(pfx_opsize),
    .pfx_adsize(pfx_adsize), .req_w64(req_w64), .mode_o(mode_o),
    .op_size_o(op_size_o), .ad_size_o(ad_size_o), .fault_o(fault_o)
  );

  // {req[3:0], lma, prot, l, d, opsz, adsz, w64, mode[1:0], op[1:0], ad[1:0], fault}
  localparam int NV = 14;
  localparam logic [17:0] VEC [NV] = '{
    {4'd3, 7'b1110000, 2'b10, 2'b01, 2'b10, 1'b0},  // R3 64-bit defaults
    {4'd4, 7'b1110001, 2'b10, 2'b10, 2'b10, 1'b0},  // R4 w64
    {4'd4, 7'b1110100, 2'b10, 2'b00, 2'b10, 1'b0},  // R4 opsize -> 16
    {4'd4, 7'b1110111, 2'b10, 2'b10, 2'b01, 1'b0},  // R4 w64 beats opsize, addr 32
    {4'd5, 7'b1101000, 2'b01, 2'b01, 2'b01, 1'b0},  // R5 compat D=1
    {4'd5, 7'b1100000, 2'b01, 2'b00, 2'b00, 1'b0},  // R5 compat D=0
    {4'd8, 7'b1100111, 2'b01, 2'b01, 2'b01, 1'b0},  // R8 toggles, w64 ignored
    {4'd8, 7'b1101101, 2'b01, 2'b00, 2'b01, 1'b0},  // R8 op toggle only
    {4'd7, 7'b0111000, 2'b00, 2'b01, 2'b01, 1'b0},  // R7 L ignored, D=1
    {4'd7, 7'b0110000, 2'b00, 2'b00, 2'b00, 1'b0},  // R7 D=0
    {4'd8, 7'b0101011, 2'b00, 2'b01, 2'b00, 1'b0},  // R8 legacy addr toggle
    {4'd9, 7'b1010000, 2'b00, 2'b00, 2'b00, 1'b0},  // R9 no prot, L=1 D=0
    {4'd9, 7'b1011000, 2'b00, 2'b01, 2'b01, 1'b0},  // R9 no prot, L=1 D=1 no fault
    {4'd6, 7'b1111000, 2'b11, 2'b01, 2'b01, 1'b1}   // R6 reserved, sizes held at 32
  };

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got mode/op/ad/fault %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] v, input logic vld);
    @(negedge clk);
    {lma_active, prot_en, cs_l, cs_d, pfx_opsize, pfx_adsize, req_w64} = v;
    in_valid = vld;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [6:0] outs();
    return {mode_o, op_size_o, ad_size_o, fault_o};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1", outs(), 7'b00_01_01_0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][13:7], 1'b1);
      check($sformatf("R%0d vec%0d", VEC[i][17:14], i), outs(), VEC[i][6:0]);
    end

    // R6: the fault strobe falls one cycle later and the outputs hold
    @(negedge clk);
    check("R6 pulse", outs(), 7'b11_01_01_0);

    // R6: a reserved decode after a 16/16 state keeps 16/16
    drive(7'b1100000, 1'b1);
    check("R5 setup", outs(), 7'b01_00_00_0);
    drive(7'b1111111, 1'b1);
    check("R6 held 16", outs(), 7'b11_00_00_1);

    // R2: input changes without the strobe have no effect
    drive(7'b1110001, 1'b0);
    check("R2 idle", outs(), 7'b11_00_00_0);
    drive(7'b0101000, 1'b0);
    check("R2 idle2", outs(), 7'b11_00_00_0);

    // R2: a one-cycle strobe result, then a hold
    drive(7'b1110010, 1'b1);
    check("R4 addr32", outs(), 7'b10_01_01_0);
    @(negedge clk);
    check("R2 hold", outs(), 7'b10_01_01_0);

    // R1: reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid", outs(), 7'b00_01_01_0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule